// File: doc/BRIEF.md
# Tiled Transfer Address Generator

This block sits beside a processing core and produces the address stream for copying a two-dimensional tile from global memory into the core's scratchpad. The core's own arithmetic pipeline does none of this work. Software fills in one of four buffer descriptors through a narrow write port, one field per write. The descriptor holds the global start, the scratchpad start, the number of rows, the elements per row, the byte size of an element, the byte pitch between rows in global memory, and a padding flag. A later ignite command names a buffer and queues it for the walker.

The walker takes queued buffers one at a time, in the order their ignites were accepted. For each buffer it issues one request per line-sized chunk on a valid/ready port. Each request carries a global read address, the matching scratchpad write address, the chunk length and the buffer index. When a row is used up, both addresses move to the start of the next row. With padding enabled, each scratchpad row is one element longer than the data it holds, which spreads successive rows across scratchpad banks. A per-buffer busy flag and a one-cycle done pulse report completion.

Top module: `tile_xfer_agen`

## Requirements
- R1: After reset all busy and done bits are 0 and `req_valid` is 0.
- R2: Configuration writes store `cfg_wdata` into the field of buffer `cfg_buf` selected by `cfg_sel`. The field codes are: 0 global start, 1 scratchpad start, 2 row count, 3 elements per row, 4 global row pitch in bytes, 5 element size in bytes, 6 padding flag (bit 0). Code 7 writes nothing. The first request of a transfer carries the stored global and scratchpad starts.
- R3: Within a row, each accepted request advances both addresses by 128 bytes. `req_len` is the smaller of 128 and the bytes still left in the row. For example, one row of 64 four-byte elements at 0x1020/0x20 gives exactly two requests, 0x1020/0x20 and 0x10A0/0xA0.
- R4: Row r (counted from 0) starts at global start + r × pitch. With padding off, its scratchpad start is scratchpad start + r × elements × size.
- R5: With padding on, the scratchpad row pitch is (elements + 1) × size.
- R6: While `req_valid` is 1 and `req_ready` is 0, the request fields and `req_valid` do not change in the next cycle.
- R7: Accepting an ignite sets busy for that buffer at the same clock edge. The edge that accepts the buffer's last request clears busy and raises that buffer's done bit for exactly one cycle.
- R8: An ignite is ignored, with busy unchanged and no requests issued, in two cases. The first is when the named buffer is already busy. The second is when the buffer's row count, element count or element size is zero.
- R9: Accepted ignites are served strictly in arrival order, one transfer at a time, and `req_buf` names the buffer being served.
- R10: A configuration write to a buffer whose busy flag is set has no effect on that descriptor.
- R11: The first request of a transfer is valid in the second cycle after its ignite is sampled if the walker is idle. When transfers are queued back to back, one idle cycle separates the last request of one transfer from the first request of the next.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cfg_we | input | 1 | Descriptor field write strobe |
| cfg_buf | input | 2 | Buffer index for the write |
| cfg_sel | input | 3 | Field code |
| cfg_wdata | input | 32 | Field value |
| ign_valid | input | 1 | Ignite strobe |
| ign_buf | input | 2 | Buffer to start |
| req_valid | output | 1 | Request present |
| req_ready | input | 1 | Request accepted when high with `req_valid` |
| req_gaddr | output | 32 | Global read byte address |
| req_saddr | output | 16 | Scratchpad write byte address |
| req_len | output | 8 | Bytes in this chunk, 1 to 128 |
| req_buf | output | 2 | Buffer being served |
| busy | output | 4 | Per-buffer busy flags |
| done | output | 4 | Per-buffer one-cycle completion pulses |

## Verification
The hardest case to reach is a buffer that has been accepted but is still waiting in the queue behind another transfer. Such a buffer is busy but has no requests on the port yet, and a repeated ignite or a descriptor write aimed at it has to be refused without disturbing the transfer already running. The stimulus gets there by igniting three buffers on consecutive cycles. It then re-ignites the first and rewrites the start of the second while both are still pending, and later re-ignites the second to show that its old start address survived. Random and forced-low ready patterns push stalls onto the short chunk at the end of a row, where the row wrap takes place.

// File: rtl/tx_pkg.sv
package tx_pkg;
  typedef enum logic [2:0] {
    FLD_GBASE = 3'd0,
    FLD_SBASE = 3'd1,
    FLD_ROWS  = 3'd2,
    FLD_COLS  = 3'd3,
    FLD_PITCH = 3'd4,
    FLD_ESIZE = 3'd5,
    FLD_PAD   = 3'd6,
    FLD_NONE  = 3'd7
  } fld_e;

  typedef enum logic {
    WK_IDLE = 1'b0,
    WK_RUN  = 1'b1
  } wk_state_e;
endpackage

// File: rtl/tx_desc_regs.sv
module tx_desc_regs
  import tx_pkg::*;
#(
  parameter int NBUF  = 4,
  parameter int GA_W  = 32,
  parameter int SA_W  = 16,
  parameter int DIM_W = 10,
  parameter int ESZ_W = 4,
  localparam int BI_W = $clog2(NBUF)
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [BI_W-1:0]  wr_buf,
  input  logic [2:0]       wr_sel,
  input  logic [GA_W-1:0]  wr_data,
  input  logic [NBUF-1:0]  lock,
  input  logic [BI_W-1:0]  rd_idx,
  output logic [GA_W-1:0]  rd_gbase,
  output logic [SA_W-1:0]  rd_sbase,
  output logic [DIM_W-1:0] rd_rows,
  output logic [DIM_W-1:0] rd_cols,
  output logic [GA_W-1:0]  rd_pitch,
  output logic [ESZ_W-1:0] rd_esize,
  output logic             rd_pad,
  output logic [NBUF-1:0]  size_ok
);
  logic [GA_W-1:0]  gb_q [NBUF];
  logic [SA_W-1:0]  sb_q [NBUF];
  logic [DIM_W-1:0] rw_q [NBUF];
  logic [DIM_W-1:0] cl_q [NBUF];
  logic [GA_W-1:0]  pt_q [NBUF];
  logic [ESZ_W-1:0] es_q [NBUF];
  logic [NBUF-1:0]  pd_q;
  logic [NBUF-1:0]  wen;

  for (genvar i = 0; i < NBUF; i++) begin : g_buf
    assign wen[i]     = wr_en && (wr_buf == BI_W'(i)) && !lock[i];
    assign size_ok[i] = (|rw_q[i]) && (|cl_q[i]) && (|es_q[i]);

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
        gb_q[i] <= '0;
        sb_q[i] <= '0;
        rw_q[i] <= '0;
        cl_q[i] <= '0;
        pt_q[i] <= '0;
        es_q[i] <= '0;
        pd_q[i] <= 1'b0;
      end else if (wen[i]) begin
        case (fld_e'(wr_sel))
          FLD_GBASE: gb_q[i] <= wr_data;
          FLD_SBASE: sb_q[i] <= SA_W'(wr_data);
          FLD_ROWS:  rw_q[i] <= DIM_W'(wr_data);
          FLD_COLS:  cl_q[i] <= DIM_W'(wr_data);
          FLD_PITCH: pt_q[i] <= wr_data;
          FLD_ESIZE: es_q[i] <= ESZ_W'(wr_data);
          FLD_PAD:   pd_q[i] <= wr_data[0];
          default:   ;
        endcase
      end
    end

    // R10
    locked_desc_stable_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $past(lock[i]) |-> ($stable(gb_q[i]) && $stable(sb_q[i]) && $stable(rw_q[i])
                          && $stable(cl_q[i]) && $stable(es_q[i])));
  end

  assign rd_gbase = gb_q[rd_idx];
  assign rd_sbase = sb_q[rd_idx];
  assign rd_rows  = rw_q[rd_idx];
  assign rd_cols  = cl_q[rd_idx];
  assign rd_pitch = pt_q[rd_idx];
  assign rd_esize = es_q[rd_idx];
  assign rd_pad   = pd_q[rd_idx];
endmodule

// File: rtl/tx_ign_fifo.sv
module tx_ign_fifo #(
  parameter int DEPTH = 4,
  parameter int IW    = 2,
  localparam int PW   = (DEPTH > 1) ? $clog2(DEPTH) : 1,
  localparam int CW   = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          push,
  input  logic [IW-1:0] push_data,
  input  logic          pop,
  output logic [IW-1:0] head,
  output logic          empty,
  output logic          full
);
  logic [IW-1:0] mem [DEPTH];
  logic [PW-1:0] wp_q, wp_d, rp_q, rp_d;
  logic [CW-1:0] cnt_q, cnt_d;

  function automatic logic [PW-1:0] nxt(input logic [PW-1:0] p);
    return (p == PW'(DEPTH - 1)) ? '0 : p + PW'(1);
  endfunction

  always_comb begin
    wp_d  = push ? nxt(wp_q) : wp_q;
    rp_d  = pop  ? nxt(rp_q) : rp_q;
    cnt_d = cnt_q + CW'(push) - CW'(pop);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wp_q  <= '0;
      rp_q  <= '0;
      cnt_q <= '0;
    end else begin
      wp_q  <= wp_d;
      rp_q  <= rp_d;
      cnt_q <= cnt_d;
    end
  end

  always_ff @(posedge clk) begin
    if (push) mem[wp_q] <= push_data;
  end

  assign head  = mem[rp_q];
  assign empty = (cnt_q == '0);
  assign full  = (cnt_q == CW'(DEPTH));

  // R9
  ign_queue_no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    push |-> !full);
  // R9
  ign_queue_no_underflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pop |-> !empty);
endmodule

// File: rtl/tx_walker.sv
module tx_walker
  import tx_pkg::*;
#(
  parameter int NBUF       = 4,
  parameter int GA_W       = 32,
  parameter int SA_W       = 16,
  parameter int DIM_W      = 10,
  parameter int ESZ_W      = 4,
  parameter int LINE_BYTES = 128,
  localparam int BI_W  = $clog2(NBUF),
  localparam int RB_W  = DIM_W + ESZ_W,
  localparam int LEN_W = $clog2(LINE_BYTES) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             q_empty,
  input  logic [BI_W-1:0]  q_buf,
  output logic             take,
  input  logic [GA_W-1:0]  d_gbase,
  input  logic [SA_W-1:0]  d_sbase,
  input  logic [DIM_W-1:0] d_rows,
  input  logic [DIM_W-1:0] d_cols,
  input  logic [GA_W-1:0]  d_pitch,
  input  logic [ESZ_W-1:0] d_esize,
  input  logic             d_pad,
  output logic             req_valid,
  input  logic             req_ready,
  output logic [GA_W-1:0]  req_gaddr,
  output logic [SA_W-1:0]  req_saddr,
  output logic [LEN_W-1:0] req_len,
  output logic [BI_W-1:0]  req_buf,
  output logic             fin,
  output logic [BI_W-1:0]  fin_buf
);
  localparam logic [RB_W-1:0] LINE_RB = RB_W'(LINE_BYTES);
  localparam logic [GA_W-1:0] LINE_GA = GA_W'(LINE_BYTES);
  localparam logic [SA_W-1:0] LINE_SA = SA_W'(LINE_BYTES);

  wk_state_e        st_q, st_d;
  logic [GA_W-1:0]  cg_q, cg_d, rg_q, rg_d, pg_q, pg_d;
  logic [SA_W-1:0]  cs_q, cs_d, rs_q, rs_d, ps_q, ps_d;
  logic [RB_W-1:0]  rb_q, rb_d, rem_q, rem_d;
  logic [DIM_W-1:0] rl_q, rl_d;
  logic [BI_W-1:0]  bf_q, bf_d;
  logic [RB_W-1:0]  rb_new;
  logic [SA_W-1:0]  sp_new;
  logic             fire, row_end, ld;

  assign take    = (st_q == WK_IDLE) && !q_empty;
  assign fire    = (st_q == WK_RUN) && req_ready;
  assign row_end = (rem_q <= LINE_RB);
  assign fin     = fire && row_end && (rl_q == DIM_W'(1));
  assign ld      = take || fire;
  assign rb_new  = RB_W'(d_cols) * RB_W'(d_esize);
  assign sp_new  = SA_W'(rb_new) + (d_pad ? SA_W'(d_esize) : '0);

  always_comb begin
    st_d  = st_q;
    cg_d  = cg_q;  rg_d = rg_q;  pg_d = pg_q;
    cs_d  = cs_q;  rs_d = rs_q;  ps_d = ps_q;
    rb_d  = rb_q;  rem_d = rem_q;
    rl_d  = rl_q;  bf_d = bf_q;
    if (take) begin
      st_d  = WK_RUN;
      cg_d  = d_gbase;  rg_d = d_gbase;  pg_d = d_pitch;
      cs_d  = d_sbase;  rs_d = d_sbase;  ps_d = sp_new;
      rb_d  = rb_new;   rem_d = rb_new;
      rl_d  = d_rows;   bf_d = q_buf;
    end else if (fire) begin
      if (!row_end) begin
        cg_d  = cg_q + LINE_GA;
        cs_d  = cs_q + LINE_SA;
        rem_d = rem_q - LINE_RB;
      end else if (rl_q != DIM_W'(1)) begin
        rg_d  = rg_q + pg_q;
        cg_d  = rg_q + pg_q;
        rs_d  = rs_q + ps_q;
        cs_d  = rs_q + ps_q;
        rem_d = rb_q;
        rl_d  = rl_q - DIM_W'(1);
      end else begin
        st_d  = WK_IDLE;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q <= WK_IDLE;
      cg_q <= '0;  rg_q <= '0;  pg_q <= '0;
      cs_q <= '0;  rs_q <= '0;  ps_q <= '0;
      rb_q <= '0;  rem_q <= '0;
      rl_q <= '0;  bf_q <= '0;
    end else begin
      st_q <= st_d;
      if (ld) begin
        cg_q <= cg_d;  rg_q <= rg_d;  pg_q <= pg_d;
        cs_q <= cs_d;  rs_q <= rs_d;  ps_q <= ps_d;
        rb_q <= rb_d;  rem_q <= rem_d;
        rl_q <= rl_d;  bf_q <= bf_d;
      end
    end
  end

  assign req_valid = (st_q == WK_RUN);
  assign req_gaddr = cg_q;
  assign req_saddr = cs_q;
  assign req_len   = row_end ? LEN_W'(rem_q) : LEN_W'(LINE_BYTES);
  assign req_buf   = bf_q;
  assign fin_buf   = bf_q;

  // R6
  req_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_ready) |=> (req_valid && $stable(req_gaddr)
                                   && $stable(req_saddr) && $stable(req_len)
                                   && $stable(req_buf)));
  // R3
  req_len_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |-> (req_len != '0) && (req_len <= LEN_W'(LINE_BYTES)));
endmodule

// File: rtl/tile_xfer_agen.sv
module tile_xfer_agen #(
  parameter int NBUF       = 4,
  parameter int GA_W       = 32,
  parameter int SA_W       = 16,
  parameter int DIM_W      = 10,
  parameter int ESZ_W      = 4,
  parameter int LINE_BYTES = 128,
  localparam int BI_W  = $clog2(NBUF),
  localparam int LEN_W = $clog2(LINE_BYTES) + 1
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cfg_we,
  input  logic [BI_W-1:0]  cfg_buf,
  input  logic [2:0]       cfg_sel,
  input  logic [GA_W-1:0]  cfg_wdata,
  input  logic             ign_valid,
  input  logic [BI_W-1:0]  ign_buf,
  output logic             req_valid,
  input  logic             req_ready,
  output logic [GA_W-1:0]  req_gaddr,
  output logic [SA_W-1:0]  req_saddr,
  output logic [LEN_W-1:0] req_len,
  output logic [BI_W-1:0]  req_buf,
  output logic [NBUF-1:0]  busy,
  output logic [NBUF-1:0]  done
);
  logic [1:0]       rsync_q;
  logic             rst_int_n;
  logic [NBUF-1:0]  busy_q, busy_d, done_q, done_d, size_ok;
  logic             ign_ok, take, q_empty, q_full, fin;
  logic [BI_W-1:0]  q_head, fin_buf;
  logic [GA_W-1:0]  d_gbase, d_pitch;
  logic [SA_W-1:0]  d_sbase;
  logic [DIM_W-1:0] d_rows, d_cols;
  logic [ESZ_W-1:0] d_esize;
  logic             d_pad;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rsync_q <= 2'b00;
    else        rsync_q <= {rsync_q[0], 1'b1};
  end
  assign rst_int_n = rsync_q[1];

  tx_desc_regs #(.NBUF(NBUF), .GA_W(GA_W), .SA_W(SA_W), .DIM_W(DIM_W), .ESZ_W(ESZ_W)) u_desc (
    .clk(clk), .rst_n(rst_int_n),
    .wr_en(cfg_we), .wr_buf(cfg_buf), .wr_sel(cfg_sel), .wr_data(cfg_wdata),
    .lock(busy_q), .rd_idx(q_head),
    .rd_gbase(d_gbase), .rd_sbase(d_sbase), .rd_rows(d_rows), .rd_cols(d_cols),
    .rd_pitch(d_pitch), .rd_esize(d_esize), .rd_pad(d_pad), .size_ok(size_ok)
  );

  assign ign_ok = ign_valid && !busy_q[ign_buf] && size_ok[ign_buf];

  tx_ign_fifo #(.DEPTH(NBUF), .IW(BI_W)) u_queue (
    .clk(clk), .rst_n(rst_int_n),
    .push(ign_ok), .push_data(ign_buf), .pop(take),
    .head(q_head), .empty(q_empty), .full(q_full)
  );

  tx_walker #(.NBUF(NBUF), .GA_W(GA_W), .SA_W(SA_W), .DIM_W(DIM_W), .ESZ_W(ESZ_W),
              .LINE_BYTES(LINE_BYTES)) u_walk (
    .clk(clk), .rst_n(rst_int_n),
    .q_empty(q_empty), .q_buf(q_head), .take(take),
    .d_gbase(d_gbase), .d_sbase(d_sbase), .d_rows(d_rows), .d_cols(d_cols),
    .d_pitch(d_pitch), .d_esize(d_esize), .d_pad(d_pad),
    .req_valid(req_valid), .req_ready(req_ready), .req_gaddr(req_gaddr),
    .req_saddr(req_saddr), .req_len(req_len), .req_buf(req_buf),
    .fin(fin), .fin_buf(fin_buf)
  );

  always_comb begin
    busy_d = busy_q;
    done_d = '0;
    if (fin) begin
      busy_d[fin_buf] = 1'b0;
      done_d[fin_buf] = 1'b1;
    end
    if (ign_ok) busy_d[ign_buf] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_int_n) begin
    if (!rst_int_n) begin
      busy_q <= '0;
      done_q <= '0;
    end else begin
      busy_q <= busy_d;
      done_q <= done_d;
    end
  end

  assign busy = busy_q;
  assign done = done_q;

  // R7
  done_onehot_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    $onehot0(done));
  // R9
  queue_never_full_on_ignite_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
    ign_ok |-> !q_full);

  for (genvar i = 0; i < NBUF; i++) begin : g_flag_chk
    // R7
    done_ends_busy_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
      done[i] |-> (!busy[i] && $past(busy[i])));
    // R8
    busy_rise_from_ignite_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
      $rose(busy[i]) |-> ($past(ign_valid) && ($past(ign_buf) == BI_W'(i))));
    // R7
    busy_fall_with_done_chk: assert property (@(posedge clk) disable iff (!rst_int_n)
      $fell(busy[i]) |-> done[i]);
  end
endmodule

// File: tb/tile_xfer_agen_bench.sv
module tile_xfer_agen_bench;
  typedef struct {
    logic [31:0] g;
    logic [15:0] s;
    logic [7:0]  l;
    logic [1:0]  b;
  } req_t;

  logic        clk, rst_n;
  logic        cfg_we, ign_valid, req_ready;
  logic [1:0]  cfg_buf, ign_buf;
  logic [2:0]  cfg_sel;
  logic [31:0] cfg_wdata;
  logic        req_valid;
  logic [31:0] req_gaddr;
  logic [15:0] req_saddr;
  logic [7:0]  req_len;
  logic [1:0]  req_buf;
  logic [3:0]  busy, done;

  int n_chk, n_err, cyc, rdy_mode;
  bit cmp_en, finished;

  logic [31:0] d_g [4];
  logic [15:0] d_s [4];
  int d_rows [4], d_cols [4], d_pitch [4], d_es [4];
  bit d_pad [4];
  logic [3:0] m_busy, m_done;
  bit m_run;
  logic [1:0] m_buf;
  int iq [$];
  req_t exq [$];
  req_t lg [$];

  tile_xfer_agen u_tile_xfer_agen (
    .clk(clk), .rst_n(rst_n), .cfg_we(cfg_we), .cfg_buf(cfg_buf), .cfg_sel(cfg_sel),
    .cfg_wdata(cfg_wdata), .ign_valid(ign_valid), .ign_buf(ign_buf),
    .req_valid(req_valid), .req_ready(req_ready), .req_gaddr(req_gaddr),
    .req_saddr(req_saddr), .req_len(req_len), .req_buf(req_buf),
    .busy(busy), .done(done)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s act=%0h exp=%0h", tag, act, exp);
    end
  endtask

  task automatic build(int b);
    for (int r = 0; r < d_rows[b]; r++) begin
      int rowb = d_cols[b] * d_es[b];
      int sp = rowb + (d_pad[b] ? d_es[b] : 0);
      for (int off = 0; off < rowb; off += 128) begin
        req_t e;
        e.g = 32'(d_g[b] + r * d_pitch[b] + off);
        e.s = 16'(d_s[b] + r * sp + off);
        e.l = 8'((rowb - off) > 128 ? 128 : (rowb - off));
        e.b = 2'(b);
        exq.push_back(e);
      end
    end
  endtask

  // behavioural reference, advanced on each clock edge
  always @(posedge clk) begin
    if (!rst_n) begin
      m_busy = '0; m_done = '0; m_run = 0; m_buf = '0;
      iq.delete(); exq.delete();
      for (int i = 0; i < 4; i++) begin
        d_g[i] = '0; d_s[i] = '0; d_rows[i] = 0; d_cols[i] = 0;
        d_pitch[i] = 0; d_es[i] = 0; d_pad[i] = 0;
      end
    end else begin
      logic [3:0] bo;
      bo = m_busy;
      m_done = '0;
      if (m_run) begin
        if (req_ready) begin
          void'(exq.pop_front());
          if (exq.size() == 0) begin
            m_run = 0; m_busy[m_buf] = 1'b0; m_done[m_buf] = 1'b1;
          end
        end
      end else if (iq.size() > 0) begin
        int b;
        b = iq.pop_front();
        m_buf = 2'(b);
        build(b);
        m_run = 1;
      end
      if (ign_valid && !bo[ign_buf] && d_rows[ign_buf] != 0 && d_cols[ign_buf] != 0
          && d_es[ign_buf] != 0) begin
        iq.push_back(int'(ign_buf));
        m_busy[ign_buf] = 1'b1;
      end
      if (cfg_we && !bo[cfg_buf]) begin
        case (cfg_sel)
          3'd0: d_g[cfg_buf] = cfg_wdata;
          3'd1: d_s[cfg_buf] = cfg_wdata[15:0];
          3'd2: d_rows[cfg_buf] = int'(cfg_wdata[9:0]);
          3'd3: d_cols[cfg_buf] = int'(cfg_wdata[9:0]);
          3'd4: d_pitch[cfg_buf] = int'(cfg_wdata);
          3'd5: d_es[cfg_buf] = int'(cfg_wdata[3:0]);
          3'd6: d_pad[cfg_buf] = cfg_wdata[0];
          default: ;
        endcase
      end
    end
  end

  // cycle-by-cycle comparison and acceptance log, away from the clock edge
  always @(negedge clk) begin
    if (cmp_en) begin
      chk("R7 busy", {28'd0, busy}, {28'd0, m_busy});
      chk("R7 done", {28'd0, done}, {28'd0, m_done});
      chk("R11 R9 req_valid", {31'd0, req_valid}, {31'd0, m_run});
      if (m_run && req_valid && exq.size() > 0) begin
        chk("R2 R3 R4 R5 gaddr", req_gaddr, exq[0].g);
        chk("R2 R3 R4 R5 saddr", {16'd0, req_saddr}, {16'd0, exq[0].s});
        chk("R3 len", {24'd0, req_len}, {24'd0, exq[0].l});
        chk("R9 buf", {30'd0, req_buf}, {30'd0, exq[0].b});
      end
      if (req_valid && req_ready) begin
        req_t e;
        e.g = req_gaddr; e.s = req_saddr; e.l = req_len; e.b = req_buf;
        lg.push_back(e);
      end
    end
  end

  always @(posedge clk) begin
    #2;
    case (rdy_mode)
      0: req_ready = 1'b1;
      1: req_ready = (($urandom % 10) < 6);
      default: req_ready = 1'b0;
    endcase
  end

  always @(posedge clk) begin
    cyc++;
    if (cyc > 150000 && !finished) begin
      finished = 1;
      n_chk++; n_err++;
      $display("FAIL watchdog act=%0d exp=done", cyc);
      $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
      $finish;
    end
  end

  task automatic tick();
    @(posedge clk); #2;
  endtask

  task automatic wr(int b, int sel, logic [31:0] v);
    cfg_we = 1'b1; cfg_buf = 2'(b); cfg_sel = 3'(sel); cfg_wdata = v;
    tick();
    cfg_we = 1'b0;
  endtask

  task automatic ign(int b);
    ign_valid = 1'b1; ign_buf = 2'(b);
    tick();
    ign_valid = 1'b0;
  endtask

  task automatic setup(int b, logic [31:0] g, logic [15:0] s, int rows, int cols,
                       int pitch, int es, int pad);
    wr(b, 0, g); wr(b, 1, {16'd0, s}); wr(b, 2, rows); wr(b, 3, cols);
    wr(b, 4, pitch); wr(b, 5, es); wr(b, 6, pad);
  endtask

  task automatic wait_idle();
    for (int k = 0; k < 5000; k++) begin
      if (busy == 4'd0 && !req_valid && done == 4'd0) break;
      tick();
    end
    tick();
  endtask

  initial begin
    n_chk = 0; n_err = 0; cyc = 0; cmp_en = 0; finished = 0; rdy_mode = 0;
    rst_n = 1'b0; cfg_we = 1'b0; ign_valid = 1'b0; req_ready = 1'b1;
    cfg_buf = '0; ign_buf = '0; cfg_sel = '0; cfg_wdata = '0;
    repeat (3) @(posedge clk);
    #2 rst_n = 1'b1;
    repeat (4) tick();
    // R1
    chk("R1 busy", {28'd0, busy}, 32'd0);
    chk("R1 done", {28'd0, done}, 32'd0);
    chk("R1 req_valid", {31'd0, req_valid}, 32'd0);
    cmp_en = 1;

    // single row, 64 x 4 bytes: exactly two lines
    setup(0, 32'h1020, 16'h20, 1, 64, 0, 4, 0);
    lg.delete();
    ign(0);
    chk("R7 busy after ignite", {28'd0, busy}, 32'd1);
    wait_idle();
    chk("R3 count", lg.size(), 2);
    if (lg.size() == 2) begin
      chk("R2 gbase", lg[0].g, 32'h1020);
      chk("R2 sbase", {16'd0, lg[0].s}, 32'h20);
      chk("R3 g step", lg[1].g, 32'h10A0);
      chk("R3 s step", {16'd0, lg[1].s}, 32'hA0);
      chk("R3 len", {24'd0, lg[1].l}, 32'd128);
    end

    // three rows of 160 bytes with padding, random ready
    rdy_mode = 1;
    setup(1, 32'h8000, 16'h100, 3, 40, 32'h400, 4, 1);
    lg.delete();
    ign(1);
    wait_idle();
    chk("R3 count rows", lg.size(), 6);
    if (lg.size() == 6) begin
      chk("R3 short len", {24'd0, lg[1].l}, 32'd32);
      chk("R4 row g", lg[2].g, 32'h8400);
      chk("R5 padded row s", {16'd0, lg[2].s}, 32'h1A4);
      chk("R5 third row s", {16'd0, lg[4].s}, 32'h248);
    end

    // same geometry without padding
    setup(2, 32'h8000, 16'h100, 3, 40, 32'h400, 4, 0);
    lg.delete();
    ign(2);
    wait_idle();
    if (lg.size() == 6) chk("R4 unpadded row s", {16'd0, lg[2].s}, 32'h1A0);
    else chk("R4 count", lg.size(), 6);

    // queued ignites, duplicate ignite, write to busy buffer
    setup(3, 32'h3000, 16'h300, 2, 8, 32'h80, 4, 0);
    lg.delete();
    ign(3); ign(1); ign(2);
    ign(3);
    wr(1, 0, 32'hDEAD00);
    wait_idle();
    begin
      int order [$];
      int n3;
      n3 = 0;
      foreach (lg[i]) begin
        if (lg[i].b == 2'd3) n3++;
        if (order.size() == 0 || order[order.size()-1] != int'(lg[i].b))
          order.push_back(int'(lg[i].b));
      end
      chk("R9 order len", order.size(), 3);
      if (order.size() == 3) begin
        chk("R9 first", order[0], 3);
        chk("R9 second", order[1], 1);
        chk("R9 third", order[2], 2);
      end
      chk("R8 dup ignite", n3, 2);
    end
    lg.delete();
    ign(1);
    wait_idle();
    if (lg.size() > 0) chk("R10 locked write", lg[0].g, 32'h8000);
    else chk("R10 count", lg.size(), 6);

    // stall holds the request
    rdy_mode = 2;
    ign(3);
    repeat (2) tick();
    begin
      logic [31:0] g0;
      g0 = req_gaddr;
      repeat (3) tick();
      chk("R6 valid held", {31'd0, req_valid}, 32'd1);
      chk("R6 addr held", req_gaddr, g0);
    end
    rdy_mode = 0;
    wait_idle();

    // zero-size descriptor
    wr(0, 2, 0);
    ign(0);
    chk("R8 zero size busy", {28'd0, busy}, 32'd0);
    repeat (3) tick();
    chk("R8 zero size no req", {31'd0, req_valid}, 32'd0);

    // unused field code
    wr(0, 2, 1);
    wr(0, 7, 32'hFFFF);
    lg.delete();
    ign(0);
    wait_idle();
    if (lg.size() > 0) chk("R2 code 7 ignored", lg[0].g, 32'h1020);
    else chk("R2 count", lg.size(), 2);

    repeat (3) tick();
    finished = 1;
    $display("  CHECKS %0d ERRORS %0d", n_chk, n_err);
    $finish;
  end
endmodule